// File: doc/BRIEF.md
# Fuse Word Auto-Read Sequencer

This block sits between a register bus and a one-time-programmable fuse array. Software first leaves manual mode off. It then writes a word address together with two command bits into the launch register. From that point the block produces the full read waveform for the fuse macro on its own. That waveform covers an active-low chip select, an active-low program enable, a load line, an address-valid line, a strobe, and the word address itself.

A single cycle counter runs from zero for the whole access. Each of the five control lines has its own programmable window. A window is described by the cycle on which the line turns on and the cycle on which it turns off again. When the strobe window closes, the block captures the 32-bit word the macro presents. After every window has closed, the block raises a sticky completion flag, which software clears by writing a one to it.

A byte offset maps to word index offset/4. Each access returns four bytes.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset, the status (0x18), data (0x20), launch (0x24) and mode (0x00) registers read zero. The window registers read their defaults, packed as on-cycle in bits 31:16 and off-cycle in bits 15:0: 0x3C select 0x0000000B, 0x40 program enable 0x0000000B, 0x44 load 0x0000000B, 0x48 address valid 0x0002000A, 0x4C strobe 0x00050008.
- R2: An access starts only on a write to 0x24 with bit 0 (auto enable) and bit 1 (read request) both set, while bit 0 of the mode register 0x00 (manual mode) is clear. Any other write to 0x24 starts nothing. The mode register reads back what was written to its bit 0.
- R3: The counter reads 0 in the first cycle after the launching write. A control line is active while on-cycle <= counter < off-cycle. Select and program enable are driven low when active; load, address valid and strobe are driven high when active.
- R4: During an access, the word address output carries launch bits 25:16.
- R5: The macro data is captured into 0x20 at the clock edge that ends the counter cycle equal to the strobe off-cycle. Until that edge, 0x20 keeps its earlier value.
- R6: Let L be the largest off-cycle of the five windows. The completion flag (0x18 bit 0) becomes visible L+1 cycles after the launching edge. It stays set until software writes 0x18 with bit 0 set; a write of zero leaves it set.
- R7: A launch write that arrives while an access is running is ignored. The running access keeps its address and its timing.
- R8: Outside an access, select and program enable are high, while load, address valid, strobe and the word address are zero.
- R9: Rewriting the window registers reshapes the waveform and moves the finish cycle. This includes windows that are empty (off <= on) and the case where every off-cycle is zero, which finishes after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| fz_csn | output | 1 | Macro chip select, active low |
| fz_pgmn | output | 1 | Macro program enable, active low |
| fz_load | output | 1 | Macro load |
| fz_addr_en | output | 1 | Macro address valid |
| fz_strobe | output | 1 | Macro read strobe |
| fz_word_addr | output | 10 | Macro word address |
| fz_dout | input | 32 | Macro data output |

## Verification
The bench compares every pin against its window on every counter cycle. A design whose window compare is inclusive at the off-cycle, or that counts from one, would show a line held one cycle too long or too short. Randomized windows include empty windows and windows that end before they start. These expose a wrong finish cycle, a finish time taken from only one pin, or a capture made on the wrong cycle; in each case the bench sees stale or misaligned data. Directed cases cover a second launch during an access, which would otherwise corrupt the address. They also cover launches blocked by manual mode or by a missing enable bit, which would otherwise start a spurious access. Finally, they check that a zero write to status does not clear the sticky flag.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;
    localparam int NUM_PINS = 5;
    localparam int CNT_W    = 16;
    localparam int REG_AW   = 8;

    typedef enum int unsigned {
        PIN_CS = 0,
        PIN_PG = 1,
        PIN_LD = 2,
        PIN_AV = 3,
        PIN_ST = 4
    } pin_e;

    typedef struct packed {
        logic [CNT_W-1:0] on_at;
        logic [CNT_W-1:0] off_at;
    } win_t;

    localparam logic [REG_AW-1:0] OFS_MODE = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h18;
    localparam logic [REG_AW-1:0] OFS_DATA = 8'h20;
    localparam logic [REG_AW-1:0] OFS_AUTO = 8'h24;
    localparam logic [REG_AW-1:0] OFS_WIN0 = 8'h3C;

    localparam int AUTO_EN_BIT = 0;
    localparam int AUTO_RD_BIT = 1;
    localparam int AUTO_A_LSB  = 16;

    function automatic win_t win_default(int idx);
        win_t w;
        case (idx)
            PIN_AV:  begin w.on_at = 16'd2; w.off_at = 16'd10; end
            PIN_ST:  begin w.on_at = 16'd5; w.off_at = 16'd8;  end
            default: begin w.on_at = 16'd0; w.off_at = 16'd11; end
        endcase
        return w;
    endfunction

    function automatic logic [REG_AW-1:0] win_ofs(int idx);
        return OFS_WIN0 + REG_AW'(4 * idx);
    endfunction

    function automatic logic in_win(logic [CNT_W-1:0] c, win_t w);
        return (c >= w.on_at) && (c < w.off_at);
    endfunction
endpackage

// File: rtl/fuse_rd_regs.sv
`timescale 1ns/1ps
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [REG_AW-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        seq_busy,
    input  logic                        cap_en,
    input  logic [DATA_W-1:0]           cap_data,
    input  logic                        fin_pulse,
    output win_t [NUM_PINS-1:0]         wins,
    output logic                        launch,
    output logic [ADDR_W-1:0]           launch_addr
);
    logic              manual_q;
    logic              done_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_hit;

    assign wr_hit      = bus_sel && bus_wr;
    assign launch      = wr_hit && (bus_addr == OFS_AUTO)
                         && bus_wdata[AUTO_EN_BIT] && bus_wdata[AUTO_RD_BIT]
                         && !manual_q && !seq_busy;
    assign launch_addr = bus_wdata[AUTO_A_LSB +: ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            manual_q <= 1'b0;
            done_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            if (wr_hit && bus_addr == OFS_MODE)
                manual_q <= bus_wdata[0];
            if (fin_pulse)
                done_q <= 1'b1;
            else if (wr_hit && bus_addr == OFS_STAT && bus_wdata[0])
                done_q <= 1'b0;
            if (cap_en)
                data_q <= cap_data;
        end
    end

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                wins[gi] <= win_default(gi);
            else if (wr_hit && bus_addr == win_ofs(gi))
                wins[gi] <= win_t'(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == OFS_MODE) bus_rdata = DATA_W'(manual_q);
            if (bus_addr == OFS_STAT) bus_rdata = DATA_W'(done_q);
            if (bus_addr == OFS_DATA) bus_rdata = data_q;
            for (int i = 0; i < NUM_PINS; i++)
                if (bus_addr == win_ofs(i)) bus_rdata = DATA_W'(wins[i]);
        end
    end

    // R6: flag rises only after the sequencer reported its final cycle
    assert_done_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(fin_pulse));
    // R5: result register changes only on a capture
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $past(cap_en));
endmodule

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic [ADDR_W-1:0]   launch_addr,
    input  win_t [NUM_PINS-1:0] wins,
    output logic                busy,
    output logic [CNT_W-1:0]    cnt,
    output logic [ADDR_W-1:0]   addr_q,
    output logic                cap_en,
    output logic                fin_pulse
);
    logic [CNT_W-1:0] last_c;

    always_comb begin
        last_c = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (wins[i].off_at > last_c) last_c = wins[i].off_at;
    end

    assign cap_en    = busy && (cnt == wins[PIN_ST].off_at);
    assign fin_pulse = busy && (cnt == last_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            addr_q <= '0;
        end else if (busy) begin
            if (cnt == last_c) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (launch) begin
            busy   <= 1'b1;
            cnt    <= '0;
            addr_q <= launch_addr;
        end
    end

    // R2: an access begins only from an accepted launch
    assert_start_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch));
    // R7: address frozen while running
    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(addr_q));
    // R3: counter never runs past the final window
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= last_c));
endmodule

// File: rtl/fuse_rd_pins.sv
`timescale 1ns/1ps
module fuse_rd_pins
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                busy,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [ADDR_W-1:0]   addr_q,
    input  win_t [NUM_PINS-1:0] wins,
    output logic                fz_csn,
    output logic                fz_pgmn,
    output logic                fz_load,
    output logic                fz_addr_en,
    output logic                fz_strobe,
    output logic [ADDR_W-1:0]   fz_word_addr
);
    logic [NUM_PINS-1:0] act;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        assign act[gi] = busy && in_win(cnt, wins[gi]);
    end

    assign fz_csn       = !act[PIN_CS];
    assign fz_pgmn      = !act[PIN_PG];
    assign fz_load      = act[PIN_LD];
    assign fz_addr_en   = act[PIN_AV];
    assign fz_strobe    = act[PIN_ST];
    assign fz_word_addr = busy ? addr_q : '0;

    // R8: idle levels outside an access
    assert_idle_pins_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fz_csn && fz_pgmn && !fz_load && !fz_addr_en
                   && !fz_strobe && fz_word_addr == '0));
endmodule

// File: rtl/fuse_autoread_ctrl.sv
`timescale 1ns/1ps
module fuse_autoread_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fz_csn,
    output logic              fz_pgmn,
    output logic              fz_load,
    output logic              fz_addr_en,
    output logic              fz_strobe,
    output logic [ADDR_W-1:0] fz_word_addr,
    input  logic [DATA_W-1:0] fz_dout
);
    win_t [NUM_PINS-1:0] wins;
    logic                launch;
    logic [ADDR_W-1:0]   launch_addr;
    logic                busy;
    logic [CNT_W-1:0]    cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic                cap_en;
    logic                fin_pulse;

    fuse_rd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_busy(busy), .cap_en(cap_en), .cap_data(fz_dout),
        .fin_pulse(fin_pulse), .wins(wins), .launch(launch),
        .launch_addr(launch_addr)
    );

    fuse_rd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .launch_addr(launch_addr),
        .wins(wins), .busy(busy), .cnt(cnt), .addr_q(addr_q),
        .cap_en(cap_en), .fin_pulse(fin_pulse)
    );

    fuse_rd_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk(clk), .rst(rst), .busy(busy), .cnt(cnt), .addr_q(addr_q),
        .wins(wins), .fz_csn(fz_csn), .fz_pgmn(fz_pgmn), .fz_load(fz_load),
        .fz_addr_en(fz_addr_en), .fz_strobe(fz_strobe),
        .fz_word_addr(fz_word_addr)
    );
endmodule

// File: tb/sim_fuse_autoread_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_autoread_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        fz_csn, fz_pgmn, fz_load, fz_addr_en, fz_strobe;
    logic [9:0]  fz_word_addr;
    logic [31:0] fz_dout;

    int checks = 0;
    int errors = 0;
    int tw_s[5];
    int tw_e[5];
    logic [31:0] exp_m;
    logic [31:0] exp_data;

    always #10 clk = ~clk;

    fuse_autoread_ctrl u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fz_csn(fz_csn), .fz_pgmn(fz_pgmn), .fz_load(fz_load),
        .fz_addr_en(fz_addr_en), .fz_strobe(fz_strobe),
        .fz_word_addr(fz_word_addr), .fz_dout(fz_dout)
    );

    function automatic logic [31:0] fuse_word(logic [9:0] a);
        return ({22'd0, a} * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // behavioural macro: latches a word when every control line is active
    always @(posedge clk) begin
        if (rst) fz_dout <= 32'd0;
        else if (!fz_csn && !fz_pgmn && fz_load && fz_addr_en && fz_strobe)
            fz_dout <= fuse_word(fz_word_addr);
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    function automatic logic win_on(int p, int i);
        return (i >= tw_s[p]) && (i < tw_e[p]);
    endfunction

    function automatic logic [14:0] pin_vec(logic on, int i, logic [9:0] a);
        if (!on) return {1'b1, 1'b1, 3'b000, 10'd0};
        return {!win_on(0, i), !win_on(1, i), win_on(2, i), win_on(3, i),
                win_on(4, i), a};
    endfunction

    function automatic logic [14:0] pins_now();
        return {fz_csn, fz_pgmn, fz_load, fz_addr_en, fz_strobe, fz_word_addr};
    endfunction

    task automatic set_win(int p, int s, int e);
        tw_s[p] = s; tw_e[p] = e;
        bus_write(8'h3C + 8'(4 * p), {16'(s), 16'(e)});
    endtask

    task automatic do_read(logic [9:0] a);
        int l = 0;
        logic [31:0] r;
        for (int p = 0; p < 5; p++) if (tw_e[p] > l) l = tw_e[p];
        bus_write(8'h24, {6'd0, a, 14'd0, 2'b11});
        for (int i = 0; i <= l; i++) begin
            check("R3 pin window", 64'(pins_now()), 64'(pin_vec(1'b1, i, a)));
            if (i == l) begin
                bus_read(8'h18, r);
                check("R6 not yet done", 64'(r), 64'd0);
            end
            if (i == tw_e[4]) exp_data = exp_m;
            if (win_on(0, i) && win_on(1, i) && win_on(2, i) && win_on(3, i) && win_on(4, i))
                exp_m = fuse_word(a);
            @(negedge clk);
        end
        bus_read(8'h18, r);
        check("R6 done flag", 64'(r), 64'd1);
        check("R8 idle after access", 64'(pins_now()), 64'(pin_vec(1'b0, 0, a)));
        bus_read(8'h20, r);
        check("R5 captured data", 64'(r), 64'(exp_data));
        bus_write(8'h18, 32'd1);
    endtask

    task automatic check_quiet(string req, int n);
        logic [31:0] r;
        for (int i = 0; i < n; i++) begin
            check(req, 64'(pins_now()), 64'(pin_vec(1'b0, 0, 10'd0)));
            @(negedge clk);
        end
        bus_read(8'h18, r);
        check(req, 64'(r), 64'd0);
        bus_read(8'h20, r);
        check(req, 64'(r), 64'(exp_data));
    endtask

    task automatic restore_defaults();
        for (int p = 0; p < 3; p++) set_win(p, 0, 11);
        set_win(3, 2, 10);
        set_win(4, 5, 8);
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        exp_m = 0; exp_data = 0;
        for (int p = 0; p < 3; p++) begin tw_s[p] = 0; tw_e[p] = 11; end
        tw_s[3] = 2; tw_e[3] = 10; tw_s[4] = 5; tw_e[4] = 8;
        rst = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset contents
        bus_read(8'h18, r); check("R1 status", 64'(r), 64'd0);
        bus_read(8'h20, r); check("R1 data", 64'(r), 64'd0);
        bus_read(8'h24, r); check("R1 launch", 64'(r), 64'd0);
        bus_read(8'h00, r); check("R1 mode", 64'(r), 64'd0);
        bus_read(8'h3C, r); check("R1 select win", 64'(r), 64'h0000000B);
        bus_read(8'h40, r); check("R1 pgm win", 64'(r), 64'h0000000B);
        bus_read(8'h44, r); check("R1 load win", 64'(r), 64'h0000000B);
        bus_read(8'h48, r); check("R1 addr win", 64'(r), 64'h0002000A);
        bus_read(8'h4C, r); check("R1 strobe win", 64'(r), 64'h00050008);
        check("R8 idle at reset", 64'(pins_now()), 64'(pin_vec(1'b0, 0, 10'd0)));

        // R3 R4 R5 default read, word index 5 = byte offset 20
        do_read(10'd5);
        do_read(10'd1023);

        // R6 sticky flag and W1C
        bus_write(8'h24, {6'd0, 10'd12, 16'd3});
        repeat (12) @(negedge clk);
        exp_data = fuse_word(10'd12); exp_m = exp_data;
        bus_write(8'h18, 32'd0);
        bus_read(8'h18, r); check("R6 zero write keeps flag", 64'(r), 64'd1);
        bus_write(8'h18, 32'd1);
        bus_read(8'h18, r); check("R6 W1C clears", 64'(r), 64'd0);

        // R7 second launch during access ignored
        bus_write(8'h24, {6'd0, 10'd7, 16'd3});
        @(negedge clk);
        bus_write(8'h24, {6'd0, 10'd9, 16'd3});
        check("R7 addr held", 64'(fz_word_addr), 64'd7);
        repeat (10) @(negedge clk);
        exp_data = fuse_word(10'd7); exp_m = exp_data;
        bus_read(8'h20, r); check("R7 data from first", 64'(r), 64'(exp_data));
        bus_read(8'h18, r); check("R7 finished once", 64'(r), 64'd1);
        check("R7 no second access", 64'(pins_now()), 64'(pin_vec(1'b0, 0, 10'd0)));
        bus_write(8'h18, 32'd1);

        // R2 manual mode blocks launch
        bus_write(8'h00, 32'd1);
        bus_read(8'h00, r); check("R2 mode readback", 64'(r), 64'd1);
        bus_write(8'h24, {6'd0, 10'd3, 16'd3});
        check_quiet("R2 manual blocks", 14);
        bus_write(8'h00, 32'd0);
        // R2 missing enable bit / missing read bit
        bus_write(8'h24, {6'd0, 10'd3, 16'd2});
        check_quiet("R2 enable missing", 14);
        bus_write(8'h24, {6'd0, 10'd3, 16'd1});
        check_quiet("R2 read missing", 14);

        // R9 all windows zero
        for (int p = 0; p < 5; p++) set_win(p, 0, 0);
        do_read(10'd44);
        // R9 randomized windows
        for (int k = 0; k < 40; k++) begin
            for (int p = 0; p < 5; p++) set_win(p, int'($urandom % 12), int'($urandom % 18));
            do_read(10'($urandom));
        end
        restore_defaults();
        bus_read(8'h4C, r); check("R9 strobe restored", 64'(r), 64'h00050008);
        do_read(10'd600);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule